// File: doc/BRIEF.md
# Translation Cache with Overlapped Page Walk

This block is a small, fully associative cache of address translations. A requester presents a virtual page number (the address with its 12 offset bits removed) on a valid/ready request channel. In the cycle the request is accepted, the block searches its entries and also issues a walk request to an external page-table walker. If an entry matches, the block pulses a cancel line to the walker and returns the frame number on the following cycle. If no entry matches, it waits for the walker's answer and forwards it to the requester. A good answer is also written into the cache.

Each entry records its own page size: small (4KB), medium (2MB, 512 small pages) or large (1GB, 262144 small pages). A medium entry ignores the lowest 9 bits of the page number when it compares, and a large entry ignores the lowest 18 bits. On a hit, those low bits pass through from the request into the returned frame number. Only one translation is in flight at a time. The request channel stays closed while a walk is pending and while a response waits to be taken. The response channel holds its data stable under back-pressure. A flush input empties the cache.

Top module: `xlate_cache`

## Requirements
- R1: `req_ready` is high only when no translation is pending and no response is waiting. A request is taken in a cycle where `req_valid` and `req_ready` are both high.
- R2: In the cycle a request is taken, `walk_req_valid` is high and `walk_req_vpn` equals `req_vpn`, whether or not the lookup hits.
- R3: On a hit, `walk_cancel` is high in the cycle the request is taken. In the next cycle `rsp_valid` rises with the cached frame number and `rsp_fault` low.
- R4: The size code is 00 for 4KB, 01 for 2MB and 10 for 1GB. A 4KB entry compares all page-number bits and returns its frame as stored. A 2MB entry ignores page-number bits [8:0] and returns them as frame bits [8:0]. A 1GB entry does the same with bits [17:0].
- R5: On a miss, no response appears until the walker answers with `walk_rsp_valid`. The walker's frame and fault appear on the response one cycle later. A good answer is installed, so the next request to that page hits.
- R6: A walker answer with the fault flag set, or with the reserved size code 11, reaches the requester with `rsp_fault` high and is never installed. A later request to that page misses.
- R7: A fill goes to the lowest-numbered invalid entry. When all 8 entries are valid, it goes to the entry under a round-robin pointer, which starts at 0 after reset and advances by one, wrapping, after each such replacement.
- R8: A flush pulse invalidates every entry in one cycle. A lookup in that same cycle is a miss, and its walk result is installed normally.
- R9: A flush in any cycle while a walk is pending, including the cycle of the walker's answer, prevents that answer from being installed. The answer is still returned.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_pfn` and `rsp_fault` hold their values. The response is consumed in the cycle `rsp_ready` is high, and `req_ready` returns high in the next cycle.
- R11: After reset `req_ready` is high, `rsp_valid`, `walk_req_valid` and `walk_cancel` are low, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can take a request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pfn | output | PFN_W | Physical frame number of the requested page |
| rsp_fault | output | 1 | Translation failed |
| walk_req_valid | output | 1 | Start a walk, one-cycle pulse |
| walk_req_vpn | output | VPN_W | Page number to walk |
| walk_cancel | output | 1 | Abandon the walk started this cycle |
| walk_rsp_valid | input | 1 | Walker answer valid |
| walk_rsp_pfn | input | PFN_W | Frame of the requested 4KB page |
| walk_rsp_size | input | 2 | Page size code of the mapping |
| walk_rsp_fault | input | 1 | Walker found no valid mapping |

## Verification
A corrupted tag, size code or valid bit shows up in the accept cycle of the next request to the affected page. In that cycle `walk_cancel` differs from what a model of the resident set expects. If the entry hits, a wrong frame base or size appears one cycle later as a wrong `rsp_pfn`. A wrong victim choice stays hidden until the evicted or surviving page is requested again. Then it shows as an unexpected miss or hit, so the bench fills past capacity and revisits pages.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // Each level of the translation tree resolves this many page-number bits.
  localparam int unsigned LVL_BITS = 9;

  typedef enum logic [1:0] {
    PG_4K   = 2'b00,
    PG_2M   = 2'b01,
    PG_1G   = 2'b10,
    PG_RSVD = 2'b11
  } pg_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_RESP = 2'b10
  } xl_state_e;
endpackage

// File: rtl/xlate_entry_array.sv
module xlate_entry_array
  import xlate_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 36,
  parameter int unsigned PFN_W   = 36,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lookup_vpn,
  output logic               hit,
  output logic [PFN_W-1:0]   hit_pfn,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  pg_size_e           fill_size,
  input  logic [PFN_W-1:0]   fill_pfn,
  output logic [ENTRIES-1:0] valid_vec
);
  localparam int unsigned MID_BITS = LVL_BITS;
  localparam int unsigned BIG_BITS = 2 * LVL_BITS;

  // Bits of the page number that lie inside the page for a given size.
  function automatic logic [VPN_W-1:0] vmask(input pg_size_e s);
    logic [VPN_W-1:0] m;
    m = '0;
    case (s)
      PG_2M:   m[MID_BITS-1:0] = '1;
      PG_1G:   m[BIG_BITS-1:0] = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [PFN_W-1:0] pmask(input pg_size_e s);
    logic [PFN_W-1:0] m;
    m = '0;
    case (s)
      PG_2M:   m[MID_BITS-1:0] = '1;
      PG_1G:   m[BIG_BITS-1:0] = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  logic             ent_v    [ENTRIES];
  pg_size_e         ent_sz   [ENTRIES];
  logic [VPN_W-1:0] ent_tag  [ENTRIES];
  logic [PFN_W-1:0] ent_base [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   sel;
  logic [PFN_W-1:0]   vpn_low;

  // Valid bits: reset and flush clear all of them at once; flush beats fill.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
    end else if (fill_en) begin
      ent_v[fill_idx] <= 1'b1;
    end
  end

  // Payload needs no reset: it is only looked at behind a set valid bit.
  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      ent_sz[fill_idx]   <= fill_size;
      ent_tag[fill_idx]  <= fill_vpn & ~vmask(fill_size);
      ent_base[fill_idx] <= fill_pfn & ~pmask(fill_size);
    end
  end

  // One comparator per entry, each masked by that entry's own size.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g]     = ent_v[g] &&
                          ((lookup_vpn & ~vmask(ent_sz[g])) == ent_tag[g]);
    assign valid_vec[g] = ent_v[g];
  end

  // Lowest matching index wins if a large and a small entry overlap.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign vpn_low = PFN_W'(lookup_vpn);
  assign hit_pfn = ent_base[sel] | (vpn_low & pmask(ent_sz[sel]));
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               commit,
  output logic [IDX_W-1:0]   victim
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim = any_free ? free_idx : rr_q;

  // The pointer only moves when it actually chose the victim.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (commit && !any_free) begin
      rr_q <= (rr_q == LAST) ? '0 : IDX_W'(rr_q + 1'b1);
    end
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int unsigned VPN_W = 36,
  parameter int unsigned PFN_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             hit,
  input  logic [PFN_W-1:0] hit_pfn,
  output logic             walk_req_valid,
  output logic [VPN_W-1:0] walk_req_vpn,
  output logic             walk_cancel,
  input  logic             walk_rsp_valid,
  input  logic [PFN_W-1:0] walk_rsp_pfn,
  input  logic [1:0]       walk_rsp_size,
  input  logic             walk_rsp_fault,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_fault,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output pg_size_e         fill_size,
  output logic [PFN_W-1:0] fill_pfn
);
  xl_state_e        state_q;
  logic [VPN_W-1:0] pend_vpn_q;
  logic             drop_q;
  logic [PFN_W-1:0] rsp_pfn_q;
  logic             rsp_fault_q;

  logic accept;
  logic hit_now;
  logic walk_done;
  logic size_ok;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign hit_now   = hit && !flush;
  assign walk_done = (state_q == ST_WAIT) && walk_rsp_valid;
  assign size_ok   = (pg_size_e'(walk_rsp_size) != PG_RSVD);

  assign req_ready      = (state_q == ST_IDLE);
  assign walk_req_valid = accept;
  assign walk_req_vpn   = req_vpn;
  assign walk_cancel    = accept && hit_now;

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_pfn   = rsp_pfn_q;
  assign rsp_fault = rsp_fault_q;

  assign fill_en   = walk_done && !walk_rsp_fault && size_ok && !drop_q && !flush;
  assign fill_vpn  = pend_vpn_q;
  assign fill_size = pg_size_e'(walk_rsp_size);
  assign fill_pfn  = walk_rsp_pfn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_vpn_q  <= '0;
      drop_q      <= 1'b0;
      rsp_pfn_q   <= '0;
      rsp_fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            pend_vpn_q <= req_vpn;
            drop_q     <= 1'b0;
            if (hit_now) begin
              state_q     <= ST_RESP;
              rsp_pfn_q   <= hit_pfn;
              rsp_fault_q <= 1'b0;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (flush) drop_q <= 1'b1;
          if (walk_rsp_valid) begin
            state_q     <= ST_RESP;
            rsp_pfn_q   <= walk_rsp_pfn;
            rsp_fault_q <= walk_rsp_fault || !size_ok;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 36,
  parameter int unsigned PFN_W   = 36,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_fault,
  output logic             walk_req_valid,
  output logic [VPN_W-1:0] walk_req_vpn,
  output logic             walk_cancel,
  input  logic             walk_rsp_valid,
  input  logic [PFN_W-1:0] walk_rsp_pfn,
  input  logic [1:0]       walk_rsp_size,
  input  logic             walk_rsp_fault
);
  logic               hit;
  logic [PFN_W-1:0]   hit_pfn;
  logic               fill_en;
  logic [VPN_W-1:0]   fill_vpn;
  pg_size_e           fill_size;
  logic [PFN_W-1:0]   fill_pfn;
  logic [IDX_W-1:0]   victim;
  logic [ENTRIES-1:0] valid_vec;

  xlate_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lookup_vpn (req_vpn),
    .hit        (hit),
    .hit_pfn    (hit_pfn),
    .fill_en    (fill_en),
    .fill_idx   (victim),
    .fill_vpn   (fill_vpn),
    .fill_size  (fill_size),
    .fill_pfn   (fill_pfn),
    .valid_vec  (valid_vec)
  );

  xlate_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .commit    (fill_en),
    .victim    (victim)
  );

  xlate_ctrl #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vpn        (req_vpn),
    .hit            (hit),
    .hit_pfn        (hit_pfn),
    .walk_req_valid (walk_req_valid),
    .walk_req_vpn   (walk_req_vpn),
    .walk_cancel    (walk_cancel),
    .walk_rsp_valid (walk_rsp_valid),
    .walk_rsp_pfn   (walk_rsp_pfn),
    .walk_rsp_size  (walk_rsp_size),
    .walk_rsp_fault (walk_rsp_fault),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_pfn        (rsp_pfn),
    .rsp_fault      (rsp_fault),
    .fill_en        (fill_en),
    .fill_vpn       (fill_vpn),
    .fill_size      (fill_size),
    .fill_pfn       (fill_pfn)
  );
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int unsigned VPN_W = 36,
  parameter int unsigned PFN_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VPN_W-1:0] req_vpn,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic             rsp_fault,
  input logic             walk_req_valid,
  input logic [VPN_W-1:0] walk_req_vpn,
  input logic             walk_cancel,
  input logic             walk_rsp_valid,
  input logic             walk_rsp_fault
);
  a_r1_closed_while_answering: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r2_walk_launched_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (walk_req_valid && walk_req_vpn == req_vpn));

  a_r3_cancel_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    walk_cancel |-> (walk_req_valid && req_ready));

  a_r3_hit_answers_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    walk_cancel |=> (rsp_valid && !rsp_fault));

  a_r5_miss_not_answered_early: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_cancel) |=> !rsp_valid);

  a_r6_fault_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_rsp_valid && walk_rsp_fault && !req_ready && !rsp_valid) |=> (rsp_valid && rsp_fault));

  a_r8_flush_forces_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && walk_req_valid) |-> !walk_cancel);

  a_r10_response_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pfn) && $stable(rsp_fault)));
endmodule

bind xlate_cache xlate_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flush          (flush),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_vpn        (req_vpn),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_pfn        (rsp_pfn),
  .rsp_fault      (rsp_fault),
  .walk_req_valid (walk_req_valid),
  .walk_req_vpn   (walk_req_vpn),
  .walk_cancel    (walk_cancel),
  .walk_rsp_valid (walk_rsp_valid),
  .walk_rsp_fault (walk_rsp_fault)
);

// File: tb/test_xlate_cache.sv
module test_xlate_cache;
  localparam int VW = 36;
  localparam int PW = 36;
  localparam int NE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VW-1:0] req_vpn = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [PW-1:0] rsp_pfn;
  logic rsp_fault;
  logic walk_req_valid;
  logic [VW-1:0] walk_req_vpn;
  logic walk_cancel;
  logic walk_rsp_valid = 1'b0;
  logic [PW-1:0] walk_rsp_pfn = '0;
  logic [1:0] walk_rsp_size = 2'b00;
  logic walk_rsp_fault = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Cache model built from the requirements.
  bit          mv   [NE];
  logic [1:0]  msz  [NE];
  logic [VW-1:0] mtag [NE];
  int          mptr = 0;

  always #5 clk = ~clk;

  xlate_cache i_xlate_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pfn(rsp_pfn), .rsp_fault(rsp_fault),
    .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn), .walk_cancel(walk_cancel),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
    .walk_rsp_size(walk_rsp_size), .walk_rsp_fault(walk_rsp_fault)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog expired: act=%0d cycles exp<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // Page-table stand-in: size from bits [35:34], fault when [33:30] is all ones.
  function automatic logic [VW-1:0] size_mask(input logic [1:0] s);
    if (s == 2'b01) return 36'h1FF;
    if (s == 2'b10) return 36'h3FFFF;
    return '0;
  endfunction

  function automatic logic [1:0] pt_size(input logic [VW-1:0] v);
    return v[35:34];
  endfunction

  function automatic bit pt_fault(input logic [VW-1:0] v);
    return v[33:30] == 4'hF;
  endfunction

  function automatic logic [PW-1:0] pt_pfn(input logic [VW-1:0] v);
    logic [VW-1:0] m;
    m = size_mask(pt_size(v));
    return ((v ^ 36'h9A5C36E10) & ~m) | (v & m);
  endfunction

  function automatic bit model_hit(input logic [VW-1:0] v);
    for (int i = 0; i < NE; i++)
      if (mv[i] && ((v & ~size_mask(msz[i])) == mtag[i])) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NE; i++) mv[i] = 1'b0;
  endtask

  task automatic model_install(input logic [VW-1:0] v, input logic [1:0] s);
    int idx;
    idx = -1;
    for (int i = NE - 1; i >= 0; i--) if (!mv[i]) idx = i;
    if (idx < 0) begin
      idx = mptr;
      mptr = (mptr + 1) % NE;
    end
    mv[idx] = 1'b1;
    msz[idx] = s;
    mtag[idx] = v & ~size_mask(s);
  endtask

  // One full transaction. Called and returns at a falling edge.
  task automatic do_req(input logic [VW-1:0] v, input bit fl_acc, input int dly,
                        input int fl_wait_at, input int stall);
    bit exp_hit;
    bit drop;
    bit exp_fault;
    logic [1:0] s;
    exp_hit = model_hit(v) && !fl_acc;
    s = pt_size(v);
    exp_fault = pt_fault(v) || (s == 2'b11);
    drop = 1'b0;
    req_valid = 1'b1;
    req_vpn = v;
    flush = fl_acc;
    #1;
    chk(req_ready == 1'b1, "R1 ready when idle", 64'(req_ready), 64'd1);
    chk(walk_req_valid && walk_req_vpn == v, "R2 walk launched with request",
        64'(walk_req_vpn), 64'(v));
    chk(walk_cancel == exp_hit, fl_acc ? "R8 flush-cycle lookup misses" : "R3/R7 cancel equals hit",
        64'(walk_cancel), 64'(exp_hit));
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    flush = 1'b0;
    if (fl_acc) model_clear();
    if (!exp_hit) begin
      for (int i = 0; i <= dly; i++) begin
        chk(!rsp_valid && !req_ready, "R5/R1 no answer while walking",
            64'({rsp_valid, req_ready}), 64'd0);
        if (i == fl_wait_at) begin
          flush = 1'b1;
          model_clear();
          drop = 1'b1;
        end
        if (i == dly) begin
          walk_rsp_valid = 1'b1;
          walk_rsp_pfn = pt_pfn(v);
          walk_rsp_size = s;
          walk_rsp_fault = pt_fault(v);
        end
        @(posedge clk); @(negedge clk);
        flush = 1'b0;
        walk_rsp_valid = 1'b0;
      end
      // R6 and R9: faults and flushed walks stay out of the model.
      if (!exp_fault && !drop) model_install(v, s);
    end
    chk(rsp_valid == 1'b1, "R3/R5 response one cycle after result", 64'(rsp_valid), 64'd1);
    chk(rsp_fault == exp_fault, "R6 fault flag", 64'(rsp_fault), 64'(exp_fault));
    if (!exp_fault)
      chk(rsp_pfn == pt_pfn(v), "R4 frame number", 64'(rsp_pfn), 64'(pt_pfn(v)));
    for (int k = 0; k < stall; k++) begin
      @(posedge clk); @(negedge clk);
      chk(rsp_valid && rsp_fault == exp_fault && (exp_fault || rsp_pfn == pt_pfn(v)),
          "R10 response held under back-pressure", 64'(rsp_pfn), 64'(pt_pfn(v)));
    end
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R10 consumed then ready", 64'({rsp_valid, req_ready}), 64'd1);
  endtask

  task automatic flush_idle();
    flush = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0;
    model_clear();
  endtask

  function automatic logic [VW-1:0] mk(input logic [1:0] s, input bit f, input logic [8:0] hi, input logic [8:0] lo);
    return {s, (f ? 4'hF : 4'h0), 12'h000, hi, lo};
  endfunction

  function automatic logic [VW-1:0] rand_vpn();
    int r;
    logic [1:0] s;
    r = $urandom % 8;
    s = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : (r == 6) ? 2'b10 : 2'b11;
    return {s, (($urandom % 10) == 0) ? 4'hF : 4'h0, 11'h000, 1'($urandom),
            6'h00, 3'($urandom), 6'h00, 3'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NE; i++) mv[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state.
    chk(req_ready && !rsp_valid && !walk_req_valid && !walk_cancel, "R11 reset outputs",
        64'({req_ready, rsp_valid, walk_req_valid, walk_cancel}), 64'h8);

    // R5/R11: empty cache misses, then the same 4KB page hits (R3).
    do_req(mk(2'b00, 0, 9'h001, 9'h002), 0, 2, -1, 0);
    do_req(mk(2'b00, 0, 9'h001, 9'h002), 0, 0, -1, 3);
    // R4: a neighbouring 4KB page must miss.
    do_req(mk(2'b00, 0, 9'h001, 9'h003), 0, 0, -1, 0);
    // R4: 2MB entry covers other low bits.
    do_req(mk(2'b01, 0, 9'h010, 9'h000), 0, 1, -1, 0);
    do_req(mk(2'b01, 0, 9'h010, 9'h1AB), 0, 0, -1, 0);
    // R4: 1GB entry covers bits [17:0].
    do_req(mk(2'b10, 0, 9'h000, 9'h000), 0, 3, -1, 0);
    do_req(mk(2'b10, 0, 9'h155, 9'h0AA), 0, 0, -1, 1);
    // R6: faulting and reserved-size answers are not installed.
    do_req(mk(2'b00, 1, 9'h002, 9'h002), 0, 0, -1, 0);
    do_req(mk(2'b00, 1, 9'h002, 9'h002), 0, 0, -1, 0);
    do_req(mk(2'b11, 0, 9'h003, 9'h003), 0, 1, -1, 0);
    do_req(mk(2'b11, 0, 9'h003, 9'h003), 0, 0, -1, 0);
    // R8: flush in the accept cycle of a would-be hit.
    do_req(mk(2'b00, 0, 9'h001, 9'h002), 1, 0, -1, 0);
    do_req(mk(2'b00, 0, 9'h001, 9'h002), 0, 0, -1, 0);
    // R9: flush during the walk and on the answer cycle.
    do_req(mk(2'b00, 0, 9'h004, 9'h004), 0, 2, 1, 0);
    do_req(mk(2'b00, 0, 9'h004, 9'h004), 0, 1, 1, 0);
    do_req(mk(2'b00, 0, 9'h004, 9'h004), 0, 0, -1, 0);
    // R7: fill past capacity, then revisit the pages.
    flush_idle();
    for (int p = 0; p < 10; p++) do_req(mk(2'b00, 0, 9'h020, 9'(p)), 0, 0, -1, 0);
    for (int p = 0; p < 10; p++) do_req(mk(2'b00, 0, 9'h020, 9'(p)), 0, 0, -1, 0);

    // Mixed random traffic.
    for (int n = 0; n < 400; n++) begin
      do_req(rand_vpn(), ($urandom % 25) == 0, $urandom % 4,
             (($urandom % 12) == 0) ? int'($urandom % 4) : -1, $urandom % 3);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule